// File: doc/BRIEF.md
# Space Vector PWM Sequencer

This block drives the three upper-leg gate signals of a three-leg voltage source inverter. Each switching period lasts a fixed number of clock ticks counted by a free-running counter. At the edge that closes one period it samples a command: the sector (1 to 6), a sequence mode, and three tick counts. One count is the zero-vector time. The other two are the on-times of the sector's two bounding active vectors. That command is held for the whole of the following period.

Inside the period the block walks the switching states of the sector. It starts from the all-low zero state, passes through the two active vectors, and uses the all-high zero state. The zero time is shared between the two zero states. Two layouts are offered. The right-aligned layout rises through the states once and ends high. The centre-symmetric layout rises to the all-high state in the middle and then retraces its steps. The active vector applied first is always the one that has exactly one leg high, so only one leg moves at each state change. A one-tick strobe marks the first tick of every period that begins at a counter wrap. Duty-cycle computation, dead time and lower-leg drive are outside the block.

Top module: `svpwm_sequencer`

## Requirements
- R1: While reset is held, and during the first period after reset, `gate_hi` is 3'b000. `period_start` is 0 during reset and during that first period.
- R2: The period counter runs from 0 to PERIOD-1 and wraps. `period_start` is 1 exactly during tick 0 of every period that follows a wrap, so it is high once every PERIOD clocks.
- R3: `sector_in`, `seq_mode`, `t_zero_in`, `t_lower_in` and `t_upper_in` are sampled only at the clock edge that ends tick PERIOD-1. Values they take at any other edge have no effect on `gate_hi`.
- R4: `gate_hi[0]`, `gate_hi[1]` and `gate_hi[2]` are legs a, b and c, with 1 meaning the leg is on the positive rail. The active vectors are V1=3'b001, V2=3'b011, V3=3'b010, V4=3'b110, V5=3'b100 and V6=3'b101. The zero states are 3'b000 and 3'b111.
- R5: Sector k is bounded by Vk (on for `t_lower_in`) and V(k+1) (on for `t_upper_in`); sector 6 uses V6 and V1. In odd sectors Vk is applied first. In even sectors V(k+1) is applied first.
- R6: With `seq_mode`=0 (right-aligned) the period is 000 for floor(z/2), then the first vector for its time, then the second vector for its time, then 111 for the remaining ticks.
- R7: With `seq_mode`=1 (symmetric) the period has seven parts: 000 for floor(z/4), first vector for floor(t/2), second vector for floor(t/2), 111 for the remaining centre ticks, second vector floor(t/2), first vector floor(t/2), and 000 floor(z/4).
- R8: A sector value of 0 or 7 holds `gate_hi` at 3'b000 for the whole period.
- R9: When every interval of the period is at least one tick long, at most one leg changes between consecutive ticks of the same period.
- R10: Over a period whose three counts sum to PERIOD, each leg is high for the sum of the intervals of the states in which that leg is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seq_mode | input | 1 | 0 right-aligned, 1 centre-symmetric |
| sector_in | input | 3 | Sector number 1..6; 0 and 7 are invalid |
| t_zero_in | input | CNT_W | Zero-vector ticks |
| t_lower_in | input | CNT_W | Ticks of the sector's lower-numbered vector |
| t_upper_in | input | CNT_W | Ticks of the sector's higher-numbered vector |
| gate_hi | output | 3 | Upper-leg gates, bit 0 leg a |
| period_start | output | 1 | High during tick 0 of each period after a wrap |

## Verification
Two events meet in one cycle: the command latch at the period wrap, and the last interval of the old pattern giving way to the first interval of the new one. In right-aligned mode all three legs fall at that moment as well. The bench drives a changing stream of unrelated commands on every tick except the one before the latch, so any sampling at the wrong edge shows up in the next period's pattern. It also switches mode and sector from one period to the next. A behavioural model builds each period's state list from the held command and compares it with `gate_hi` and `period_start` on every clock.

// File: rtl/svpwm_pkg.sv
// Shared types and vector table for the space vector sequencer.
package svpwm_pkg;

    typedef enum logic {
        SEQ_RIGHT  = 1'b0,
        SEQ_CENTER = 1'b1
    } seq_mode_e;

    typedef logic [2:0] leg_state_t;

    localparam leg_state_t ST_ALL_LOW  = 3'b000;
    localparam leg_state_t ST_ALL_HIGH = 3'b111;

    // Active vector k (1..6) as upper-leg levels, bit 0 = leg a.
    function automatic leg_state_t active_vec(input logic [2:0] k);
        case (k)
            3'd1:    active_vec = 3'b001;
            3'd2:    active_vec = 3'b011;
            3'd3:    active_vec = 3'b010;
            3'd4:    active_vec = 3'b110;
            3'd5:    active_vec = 3'b100;
            3'd6:    active_vec = 3'b101;
            default: active_vec = ST_ALL_LOW;
        endcase
    endfunction

endpackage

// File: rtl/svpwm_period_counter.sv
// Free-running switching-period counter.
// Counts 0..PERIOD-1; flags the last tick and strobes the first tick after a wrap.
// Assumes PERIOD >= 2 and PERIOD < 2**CNT_W.
module svpwm_period_counter #(
    parameter int PERIOD = 40,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             last_tick,
    output logic             start_strobe
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    assign last_tick = (cnt == LAST);

    // Advance the tick count and wrap at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (last_tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Strobe tick 0 of every period entered through a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) start_strobe <= 1'b0;
        else        start_strobe <= last_tick;
    end
endmodule

// File: rtl/svpwm_cmd_latch.sv
// Samples the per-period command on load and resolves the sector into
// an ordered pair of active vectors with their durations.
// The first vector is always the single-high one, so leaving 000 moves one leg.
module svpwm_cmd_latch
    import svpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       sector,
    input  logic             mode_in,
    input  logic [CNT_W-1:0] z_in,
    input  logic [CNT_W-1:0] lo_in,
    input  logic [CNT_W-1:0] up_in,
    output logic             valid,
    output seq_mode_e        mode_q,
    output leg_state_t       vec_first,
    output leg_state_t       vec_second,
    output logic [CNT_W-1:0] t_first,
    output logic [CNT_W-1:0] t_second,
    output logic [CNT_W-1:0] t_zero
);
    logic [2:0] next_sec;
    logic       odd_sec;
    logic       sec_ok;

    // Neighbour vector index and sector parity.
    always_comb begin
        next_sec = (sector == 3'd6) ? 3'd1 : sector + 3'd1;
        odd_sec  = sector[0];
        sec_ok   = (sector != 3'd0) && (sector != 3'd7);
    end

    // Hold the resolved command for the whole period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid      <= 1'b0;
            mode_q     <= SEQ_RIGHT;
            vec_first  <= ST_ALL_LOW;
            vec_second <= ST_ALL_LOW;
            t_first    <= '0;
            t_second   <= '0;
            t_zero     <= '0;
        end else if (load) begin
            valid      <= sec_ok;
            mode_q     <= seq_mode_e'(mode_in);
            vec_first  <= odd_sec ? active_vec(sector)   : active_vec(next_sec);
            vec_second <= odd_sec ? active_vec(next_sec) : active_vec(sector);
            t_first    <= odd_sec ? lo_in : up_in;
            t_second   <= odd_sec ? up_in : lo_in;
            t_zero     <= z_in;
        end
    end
endmodule

// File: rtl/svpwm_pattern.sv
// Maps the tick count to a switching state from the held command.
// Boundaries are compared against the count; no per-interval counters.
// Assumes the held counts sum to PERIOD; truncation leftovers land in 111.
module svpwm_pattern
    import svpwm_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int CNT_W  = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             valid,
    input  seq_mode_e        mode_q,
    input  leg_state_t       vec_first,
    input  leg_state_t       vec_second,
    input  logic [CNT_W-1:0] t_first,
    input  logic [CNT_W-1:0] t_second,
    input  logic [CNT_W-1:0] t_zero,
    output leg_state_t       state
);
    localparam int EW = CNT_W + 2;
    localparam logic [EW-1:0] P_E = EW'(PERIOD);

    logic [EW-1:0] c, zf, tf, ts;
    logic [EW-1:0] r0, r1, r2;
    logic [EW-1:0] s0, s1, s2, s3, s4, s5;
    leg_state_t    st_right, st_center;

    // Widen the operands so sums cannot overflow.
    always_comb begin
        c  = EW'(cnt);
        zf = EW'(t_zero);
        tf = EW'(t_first);
        ts = EW'(t_second);
    end

    // Right-aligned boundaries and state.
    always_comb begin
        r0 = zf >> 1;
        r1 = r0 + tf;
        r2 = r1 + ts;
        if      (c < r0) st_right = ST_ALL_LOW;
        else if (c < r1) st_right = vec_first;
        else if (c < r2) st_right = vec_second;
        else             st_right = ST_ALL_HIGH;
    end

    // Centre-symmetric boundaries and state.
    always_comb begin
        s0 = zf >> 2;
        s1 = s0 + (tf >> 1);
        s2 = s1 + (ts >> 1);
        s3 = P_E - s2;
        s4 = P_E - s1;
        s5 = P_E - s0;
        if      (c < s0) st_center = ST_ALL_LOW;
        else if (c < s1) st_center = vec_first;
        else if (c < s2) st_center = vec_second;
        else if (c < s3) st_center = ST_ALL_HIGH;
        else if (c < s4) st_center = vec_second;
        else if (c < s5) st_center = vec_first;
        else             st_center = ST_ALL_LOW;
    end

    // Pick the layout; an invalid sector parks every leg low.
    always_comb begin
        if (!valid)                    state = ST_ALL_LOW;
        else if (mode_q == SEQ_CENTER) state = st_center;
        else                           state = st_right;
    end
endmodule

// File: rtl/svpwm_sequencer.sv
// Space vector PWM sequencer top: period counter, command latch, state decode.
// Gates are decoded from registered count and command only.
// Assumes commands whose three counts sum to PERIOD.
module svpwm_sequencer
    import svpwm_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_mode,
    input  logic [2:0]       sector_in,
    input  logic [CNT_W-1:0] t_zero_in,
    input  logic [CNT_W-1:0] t_lower_in,
    input  logic [CNT_W-1:0] t_upper_in,
    output logic [2:0]       gate_hi,
    output logic             period_start
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             cmd_valid;
    seq_mode_e        mode_q;
    leg_state_t       vec_first, vec_second, state;
    logic [CNT_W-1:0] t_first, t_second, t_zero;

    svpwm_period_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
        .last_tick(wrap), .start_strobe(period_start)
    );

    svpwm_cmd_latch #(.CNT_W(CNT_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .load(wrap),
        .sector(sector_in), .mode_in(seq_mode),
        .z_in(t_zero_in), .lo_in(t_lower_in), .up_in(t_upper_in),
        .valid(cmd_valid), .mode_q(mode_q),
        .vec_first(vec_first), .vec_second(vec_second),
        .t_first(t_first), .t_second(t_second), .t_zero(t_zero)
    );

    svpwm_pattern #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_pat (
        .cnt(cnt_q), .valid(cmd_valid), .mode_q(mode_q),
        .vec_first(vec_first), .vec_second(vec_second),
        .t_first(t_first), .t_second(t_second), .t_zero(t_zero),
        .state(state)
    );

    assign gate_hi = state;
endmodule

// File: rtl/svpwm_sequencer_checker.sv
// Temporal checks on the sequencer, bound to its top module.
module svpwm_sequencer_checker #(
    parameter int PERIOD = 40,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_start,
    input logic [2:0]       gate_hi,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cmd_valid,
    input logic             mode_q,
    input logic [CNT_W-1:0] t_first,
    input logic [CNT_W-1:0] t_second,
    input logic [CNT_W-1:0] t_zero
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    a_r2_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> cnt_q == '0);

    a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> ($stable(t_zero) && $stable(t_first) &&
                           $stable(t_second) && $stable(mode_q) && $stable(cmd_valid)));

    a_r8_invalid_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> gate_hi == 3'b000);

    a_r6_right_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST && cmd_valid && !mode_q && t_zero != '0) |-> gate_hi == 3'b111);

    a_r7_center_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST && cmd_valid && mode_q && t_zero >= CNT_W'(4)) |-> gate_hi == 3'b000);

    a_r9_one_leg_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && cmd_valid && t_zero >= CNT_W'(4) &&
         t_first >= CNT_W'(2) && t_second >= CNT_W'(2))
        |-> $countones(gate_hi ^ $past(gate_hi)) <= 1);
endmodule

bind svpwm_sequencer svpwm_sequencer_checker #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .gate_hi(gate_hi),
    .cnt_q(cnt_q), .cmd_valid(cmd_valid), .mode_q(mode_q),
    .t_first(t_first), .t_second(t_second), .t_zero(t_zero)
);

// File: tb/svpwm_sequencer_bench.sv
module svpwm_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 40;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seq_mode = 1'b0;
    logic [2:0]    sector_in = 3'd0;
    logic [CW-1:0] t_zero_in = '0, t_lower_in = '0, t_upper_in = '0;
    logic [2:0]    gate_hi;
    logic          period_start;

    svpwm_sequencer #(.PERIOD(P), .CNT_W(CW)) u_svpwm_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .sector_in(sector_in),
        .t_zero_in(t_zero_in), .t_lower_in(t_lower_in), .t_upper_in(t_upper_in),
        .gate_hi(gate_hi), .period_start(period_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Command list.
    int q_sec[$], q_mode[$], q_z[$], q_lo[$], q_up[$];
    task automatic add(int s, int m, int z, int lo, int up);
        q_sec.push_back(s); q_mode.push_back(m);
        q_z.push_back(z); q_lo.push_back(lo); q_up.push_back(up);
    endtask

    // Reference pattern for one period.
    logic [2:0] pat[$];
    bit         runs_ok;
    string      tag;

    function automatic logic [2:0] vec(int k);
        case (k)
            1: return 3'b001; 2: return 3'b011; 3: return 3'b010;
            4: return 3'b110; 5: return 3'b100; default: return 3'b101;
        endcase
    endfunction

    task automatic run(logic [2:0] v, int n);
        if (n <= 0) runs_ok = 0;
        repeat (n) pat.push_back(v);
    endtask

    task automatic build(int s, int m, int z, int lo, int up);
        logic [2:0] f, sv;
        int tf, ts;
        pat.delete();
        runs_ok = 1;
        if (s < 1 || s > 6) begin
            repeat (P) pat.push_back(3'b000);
            tag = "R3 R4 R8";
            return;
        end
        if ($countones(vec(s)) == 1) begin f = vec(s); tf = lo; sv = vec(s % 6 + 1); ts = up; end
        else begin f = vec(s % 6 + 1); tf = up; sv = vec(s); ts = lo; end
        if (m == 0) begin
            tag = "R3 R4 R5 R6";
            run(3'b000, z / 2); run(f, tf); run(sv, ts);
            run(3'b111, P - pat.size());
        end else begin
            tag = "R3 R4 R5 R7";
            run(3'b000, z / 4); run(f, tf / 2); run(sv, ts / 2);
            run(3'b111, P - 2 * (z / 4 + tf / 2 + ts / 2));
            run(sv, ts / 2); run(f, tf / 2); run(3'b000, z / 4);
        end
    endtask

    initial begin
        // Stimulus plan.
        add(1, 0, 10, 20, 10);
        for (int s = 1; s <= 6; s++) add(s, 0, 9, 17, 14);   // odd zero time
        for (int s = 1; s <= 6; s++) add(s, 1, 12, 16, 12);
        for (int s = 1; s <= 6; s++) add(s, 1, 7, 19, 14);   // truncation
        add(0, 0, 10, 20, 10);                                // invalid
        add(2, 1, 3, 20, 17);
        add(7, 1, 12, 16, 12);                                // invalid
        add(3, 0, 0, 25, 15);                                 // no zero time
        add(3, 1, 0, 25, 15);
        add(2, 1, 20, 0, 20);                                 // empty vector
        add(5, 1, 40, 0, 0);                                  // zero only
        add(4, 0, 40, 0, 0);
        add(6, 0, 10, 12, 18);
        add(6, 1, 10, 12, 18);
    end

    initial begin
        int m_cnt, cidx, hi[3], exp_hi[3];
        bit started;
        logic [2:0] prev;

        // R1: reset state.
        repeat (3) begin
            @(negedge clk);
            check("R1 gate in reset", int'(gate_hi), 0);
            check("R1 strobe in reset", int'(period_start), 0);
        end
        rst_n = 1'b1;
        pat.delete();
        repeat (P) pat.push_back(3'b000);
        tag = "R1"; runs_ok = 1;
        m_cnt = 0; cidx = 0; started = 0; prev = 3'b000;
        hi = '{0, 0, 0};

        forever begin
            check({tag, " gate"}, int'(gate_hi), int'(pat[m_cnt]));
            check("R2 period_start", int'(period_start), (m_cnt == 0 && started) ? 1 : 0);
            if (m_cnt != 0 && runs_ok)
                check("R9 legs moving", ($countones(gate_hi ^ prev) <= 1) ? 1 : 0, 1);
            prev = gate_hi;
            for (int i = 0; i < 3; i++) if (gate_hi[i]) hi[i]++;
            if (m_cnt == P - 1) begin
                exp_hi = '{0, 0, 0};
                foreach (pat[j]) for (int i = 0; i < 3; i++) if (pat[j][i]) exp_hi[i]++;
                for (int i = 0; i < 3; i++) check("R10 leg high time", hi[i], exp_hi[i]);
                hi = '{0, 0, 0};
                if (cidx >= q_sec.size()) break;
                sector_in  = 3'(q_sec[cidx]);
                seq_mode   = q_mode[cidx][0];
                t_zero_in  = CW'(q_z[cidx]);
                t_lower_in = CW'(q_lo[cidx]);
                t_upper_in = CW'(q_up[cidx]);
                build(q_sec[cidx], q_mode[cidx], q_z[cidx], q_lo[cidx], q_up[cidx]);
                cidx++;
                started = 1;
                m_cnt = 0;
            end else begin
                // R3: unrelated values away from the sampling edge.
                sector_in  = 3'((m_cnt * 5 + cidx) % 8);
                seq_mode   = 1'((m_cnt + cidx) % 2);
                t_zero_in  = CW'((m_cnt * 7) % 41);
                t_lower_in = CW'((m_cnt * 3 + 1) % 37);
                t_upper_in = CW'((m_cnt * 11 + 5) % 29);
                m_cnt++;
            end
            @(negedge clk);
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule